// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Limit Compare

This block keeps a wide free-running count that advances once every 32 core clocks. With the default width the count is 52 bits. A 400 MHz core clock gives a 12.5 MHz count rate, one step every 80 ns. The count goes straight out on a port, and software can also read it at a fixed register offset. The count cannot be written.

A separate 24-bit limit register is compared with the low bits of the count. When an increment brings those low bits to the limit value, the block raises a single-cycle timer request. That request feeds the timer source bit (bit 50) of an interrupt controller outside this block.

A third register offset is write-only. A write there forces the same request at once, so software can raise the timer event without waiting for a match. Reads of the registers complete on the next cycle.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: While reset is low and on the first cycle after it, the count output is zero, the timer request is low, read-valid is low, read data is zero, and the limit reads back as zero.
- R2: The count increments by exactly one every 32 clocks. The first increment shows on the count output after the 32nd rising edge following reset release, and the count is stable between increments.
- R3: From all ones the count wraps to zero, with no other effect on its timing.
- R4: The timer request is high for one cycle in exactly the cycle in which an increment makes the low LIM_W count bits equal the limit. Holding a matching value from reset does not raise it.
- R5: A write at offset 0x30000 loads the low LIM_W bits of the write data into the limit and drops the upper bits. A read at that offset returns the limit zero-extended.
- R6: A read at offset 0x20000 returns the count as it stood in the cycle of the request, zero-extended to the data width.
- R7: A write at offset 0x20000 leaves the count unchanged.
- R8: A write at offset 0x40000 raises the timer request in the next cycle, for one cycle. A read at that offset returns zero. Accesses at any other offset return zero and change nothing.
- R9: Read-valid is high exactly in the cycle after a read request. Read data is zero whenever read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (20) | Register byte offset |
| bus_wdata | input | DATA_W (64) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | DATA_W (64) | Read data, zero when not valid |
| count_o | output | CNT_W (52) | Current count value |
| timer_irq | output | 1 | Single-cycle timer request to the interrupt controller |

## Verification
The hardest case to reach from the ports is the count wrap and the carry into bits above the compared field. At 52 bits the wrap would take about 2^57 clocks. The bench therefore runs a second instance with an 8-bit count and a 6-bit limit on the same register bus. At that size the wrap arrives after 8192 clocks and the compare matches again every 64 increments. A cycle-accurate reference model runs for both instances and is compared with every output on every cycle.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_LIMIT,
        SEL_TRIG
    } reg_sel_e;

    function automatic reg_sel_e sel_of(input logic [31:0] addr,
                                        input logic [31:0] count_ofs,
                                        input logic [31:0] limit_ofs,
                                        input logic [31:0] trig_ofs);
        if (addr == count_ofs)      return SEL_COUNT;
        else if (addr == limit_ofs) return SEL_LIMIT;
        else if (addr == trig_ofs)  return SEL_TRIG;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (PRE_W == 0) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_div
            typedef struct packed {
                logic [PRE_W-1:0] phase;
            } pre_state_t;

            pre_state_t st_d, st_q;

            always_comb begin
                st_d       = st_q;
                st_d.phase = st_q.phase + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            // the last phase before the wrap is the step cycle
            assign tick_o = &st_q.phase;
        end
    endgenerate

endmodule

// File: rtl/wide_counter.sv
module wide_counter #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] inc_o
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] plus_one;

    always_comb begin
        plus_one = st_q.value + 1'b1;
        st_d     = st_q;
        if (tick_i) st_d.value = plus_one;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.value;
    assign inc_o   = plus_one;

endmodule

// File: rtl/limit_compare.sv
module limit_compare #(
    parameter int LIM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [LIM_W-1:0] inc_low_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             force_i,
    output logic             irq_o
);

    typedef struct packed {
        logic irq;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // registered so the pulse lines up with the matching count value
        st_d.irq = (tick_i && (inc_low_i == limit_i)) || force_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer #(
    parameter int                CNT_W     = 52,
    parameter int                LIM_W     = 24,
    parameter int                PRE_W     = 5,
    parameter int                ADDR_W    = 20,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] COUNT_OFS = 20'h20000,
    parameter logic [ADDR_W-1:0] LIMIT_OFS = 20'h30000,
    parameter logic [ADDR_W-1:0] TRIG_OFS  = 20'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              timer_irq
);
    import ptimer_pkg::*;

    typedef struct packed {
        logic [LIM_W-1:0]  limit;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic             tick;
    logic [CNT_W-1:0] count_val;
    logic [CNT_W-1:0] count_inc;
    logic             trig_wr;
    reg_sel_e         sel;

    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    wide_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .count_o (count_val),
        .inc_o   (count_inc)
    );

    limit_compare #(.LIM_W(LIM_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .inc_low_i (count_inc[LIM_W-1:0]),
        .limit_i   (ctl_q.limit),
        .force_i   (trig_wr),
        .irq_o     (timer_irq)
    );

    always_comb begin
        sel     = sel_of(32'(bus_addr), 32'(COUNT_OFS), 32'(LIMIT_OFS), 32'(TRIG_OFS));
        trig_wr = bus_valid && bus_write && (sel == SEL_TRIG);

        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.rd_data  = '0;

        if (bus_valid && bus_write && (sel == SEL_LIMIT))
            ctl_d.limit = bus_wdata[LIM_W-1:0];

        if (bus_valid && !bus_write) begin
            ctl_d.rd_valid = 1'b1;
            unique case (sel)
                SEL_COUNT: ctl_d.rd_data = DATA_W'(count_val);
                SEL_LIMIT: ctl_d.rd_data = DATA_W'(ctl_q.limit);
                default:   ctl_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_valid = ctl_q.rd_valid;
    assign rd_data  = ctl_q.rd_data;
    assign count_o  = count_val;

endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
    parameter int                CNT_W    = 52,
    parameter int                LIM_W    = 24,
    parameter int                ADDR_W   = 20,
    parameter int                DATA_W   = 64,
    parameter logic [ADDR_W-1:0] TRIG_OFS = 20'h40000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  count_o,
    input logic              timer_irq,
    input logic [LIM_W-1:0]  limit_q,
    input logic              tick
);

    logic trig_wr_c;
    logic rd_req_c;
    assign trig_wr_c = bus_valid && bus_write && (bus_addr == TRIG_OFS);
    assign rd_req_c  = bus_valid && !bus_write;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(count_o));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !$past(trig_wr_c)) |->
            ($past(tick) && (count_o[LIM_W-1:0] == $past(limit_q))));

    assert_trig_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_c |=> timer_irq);

    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_c |=> rd_valid);

    assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

bind prescaled_cmp_timer ptimer_checker #(
    .CNT_W    (CNT_W),
    .LIM_W    (LIM_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TRIG_OFS (TRIG_OFS)
) u_ptimer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .count_o   (count_o),
    .timer_irq (timer_irq),
    .limit_q   (ctl_q.limit),
    .tick      (tick)
);

// File: tb/test_prescaled_cmp_timer.sv
module test_prescaled_cmp_timer;

    localparam logic [19:0] A_CNT = 20'h20000;
    localparam logic [19:0] A_LIM = 20'h30000;
    localparam logic [19:0] A_TRG = 20'h40000;
    localparam logic [63:0] CMASK [2] = '{64'h000F_FFFF_FFFF_FFFF, 64'hFF};
    localparam logic [63:0] LMASK [2] = '{64'hFF_FFFF, 64'h3F};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;

    logic        rv_a, rv_b, irq_a, irq_b;
    logic [63:0] rd_a, rd_b;
    logic [51:0] cnt_a;
    logic [7:0]  cnt_b;

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    prescaled_cmp_timer i_prescaled_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rv_a), .rd_data(rd_a),
        .count_o(cnt_a), .timer_irq(irq_a)
    );

    prescaled_cmp_timer #(.CNT_W(8), .LIM_W(6)) i_prescaled_cmp_timer_narrow (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rv_b), .rd_data(rd_b),
        .count_o(cnt_b), .timer_irq(irq_b)
    );

    logic [63:0] obs_cnt [2];
    logic [63:0] obs_rd  [2];
    logic        obs_irq [2];
    logic        obs_rv  [2];
    assign obs_cnt[0] = 64'(cnt_a);
    assign obs_cnt[1] = 64'(cnt_b);
    assign obs_rd[0]  = rd_a;
    assign obs_rd[1]  = rd_b;
    assign obs_irq[0] = irq_a;
    assign obs_irq[1] = irq_b;
    assign obs_rv[0]  = rv_a;
    assign obs_rv[1]  = rv_b;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    logic [63:0] m_cnt [2];
    logic [63:0] m_lim [2];
    logic [63:0] m_rd  [2];
    logic        m_irq [2];
    logic        m_rv  [2];
    logic        m_trig;
    int          m_pre;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] <= '0; m_lim[k] <= '0; m_rd[k] <= '0;
                m_irq[k] <= 1'b0; m_rv[k] <= 1'b0;
            end
            m_pre  <= 0;
            m_trig <= 1'b0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                automatic logic [63:0] nxt = (m_cnt[k] + 64'd1) & CMASK[k];
                automatic bit trg = bus_valid && bus_write && bus_addr == A_TRG;
                automatic bit rdq = bus_valid && !bus_write;
                m_irq[k] <= ((m_pre == 31) && ((nxt & LMASK[k]) == m_lim[k])) || trg;
                if (m_pre == 31) m_cnt[k] <= nxt;
                if (bus_valid && bus_write && bus_addr == A_LIM) m_lim[k] <= bus_wdata & LMASK[k];
                m_rv[k] <= rdq;
                m_rd[k] <= !rdq ? 64'd0 : (bus_addr == A_CNT) ? m_cnt[k] :
                           (bus_addr == A_LIM) ? m_lim[k] : 64'd0;
            end
            m_trig <= bus_valid && bus_write && bus_addr == A_TRG;
            m_pre  <= (m_pre + 1) % 32;
        end
    end

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            for (int k = 0; k < 2; k++) begin
                chk(obs_cnt[k] == m_cnt[k], "R2 count", obs_cnt[k], m_cnt[k]);
                chk(obs_irq[k] == m_irq[k], m_trig ? "R8 irq" : "R4 irq",
                    64'(obs_irq[k]), 64'(m_irq[k]));
                chk(obs_rv[k] == m_rv[k], "R9 rd_valid", 64'(obs_rv[k]), 64'(m_rv[k]));
                chk(obs_rd[k] == m_rd[k], "R6 rd_data", obs_rd[k], m_rd[k]);
            end
        end
    end

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_LIM,    64'd0,                   64'd0,        8'd1}, // R1 limit after reset
        '{1'b1, A_LIM,    64'hFFFF_FFFF_FF12_3456, 64'd0,        8'd5}, // R5 upper bits dropped
        '{1'b0, A_LIM,    64'd0,                   64'h12_3456,  8'd5},
        '{1'b1, A_CNT,    64'h5555,                64'd0,        8'd7}, // R7 ignored write
        '{1'b0, A_TRG,    64'd0,                   64'd0,        8'd8}, // R8 trigger reads zero
        '{1'b0, 20'h10000,64'd0,                   64'd0,        8'd8}, // R8 unmapped read
        '{1'b1, 20'h30008,64'h77,                  64'd0,        8'd8}, // R8 unmapped write
        '{1'b0, A_LIM,    64'd0,                   64'h12_3456,  8'd8},
        '{1'b1, A_LIM,    64'h100_0002,            64'd0,        8'd5},
        '{1'b0, A_LIM,    64'd0,                   64'd2,        8'd5}
    };

    task automatic bus_op(input logic wr, input logic [19:0] addr, input logic [63:0] data);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] cap;
        logic [23:0] tgt;
        bit seen;
        int gap;

        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        chk(cnt_a == '0 && cnt_b == '0, "R1 count", 64'(cnt_a), 64'd0);
        chk(!irq_a && !irq_b, "R1 irq", 64'(irq_a), 64'd0);
        chk(!rv_a && !rv_b && rd_a == '0 && rd_b == '0, "R1 read port", rd_a, 64'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(cnt_a == '0 && !irq_a, "R1 first cycle", 64'(cnt_a), 64'd0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            if (!VECS[i].wr)
                chk(rd_a == VECS[i].exp, $sformatf("R%0d table row %0d", VECS[i].req, i),
                    rd_a, VECS[i].exp);
        end

        // R6: count read returns the value at the request cycle
        cap = 64'(cnt_a);
        bus_op(1'b0, A_CNT, '0);
        chk(rv_a && rd_a == cap, "R6 count read", rd_a, cap);

        // R7: count write leaves the count on its own course
        bus_op(1'b1, A_CNT, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(64'(cnt_a) == m_cnt[0] && cnt_a != 52'hF_FFFF_FFFF_FFFF, "R7 count write", 64'(cnt_a), m_cnt[0]);

        // R4: match a limit a few steps ahead
        tgt = cnt_a[23:0] + 24'd3;
        bus_op(1'b1, A_LIM, 64'(tgt));
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (irq_a) begin
                seen = 1'b1;
                chk(cnt_a[23:0] == tgt, "R4 match value", 64'(cnt_a[23:0]), 64'(tgt));
            end
        end
        chk(seen, "R4 irq seen", 64'(seen), 64'd1);
        @(negedge clk);
        chk(!irq_a, "R4 single cycle", 64'(irq_a), 64'd0);

        // R8: forced event
        bus_op(1'b1, A_TRG, 64'h1);
        chk(irq_a, "R8 trigger pulse", 64'(irq_a), 64'd1);
        @(negedge clk);
        chk(!irq_a, "R8 trigger one cycle", 64'(irq_a), 64'd0);

        // R3 and R2 on the narrow instance: wrap and interval
        for (int i = 0; i < 12000 && cnt_b != 8'hFF; i++) @(negedge clk);
        chk(cnt_b == 8'hFF, "R3 reached all ones", 64'(cnt_b), 64'hFF);
        gap = 0;
        for (int i = 0; i < 40 && cnt_b == 8'hFF; i++) begin
            @(negedge clk);
            gap++;
        end
        chk(cnt_b == 8'h00, "R3 wrap to zero", 64'(cnt_b), 64'd0);
        chk(gap == 32, "R2 step interval", 64'(gap), 64'd32);

        repeat (40) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule